// File: doc/BRIEF.md
# Fragment Chunk Packer

The packer sits after a rasterizer. Quads arrive one at a time, each with a 4-bit coverage mask, an x/y position and a triangle uniform word. Quads with no covered pixels are dropped. Every covered quad is appended to a chunk of QPC quad slots, which is 16 fragments with the default QPC = 4. A chunk therefore carries data at three rates:
- a liveness bit per fragment;
- an x/y position per quad;
- a small table of per-triangle uniform words, which each quad references through a slot index.

A chunk is handed to the shading stage as soon as its last quad slot fills. If the triangle continues, its remaining quads go into a fresh chunk. A quad flagged as the end of the stream commits whatever partial chunk remains, with its unused slots zeroed. The output is a single holding register with valid/ready. The quad input stalls while a committed chunk waits to be taken.

Upstream marks the first quad of each triangle with `in_first` and holds `in_uni` constant across all quads of that triangle.

Top module: `frag_chunk_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted quad with `in_mask` = 0 changes neither the chunk contents nor its counts, apart from the commit caused by `in_last`.
- R3: The k-th covered quad accepted into a chunk (k from 0) places its mask at `out_live[4k+3:4k]`, with bit i being fragment i of the quad. Its x goes to `out_qx[XW*k +: XW]` and its y goes to `out_qy[YW*k +: YW]`.
- R4: A chunk commits in the cycle after its QPC-th covered quad is accepted. The next covered quad starts a new chunk at slot 0.
- R5: The first covered quad of a triangle within a chunk writes `in_uni` into the next free uniform slot; slots are numbered from 0 in allocation order within the chunk. That quad and every later quad of the same triangle in the chunk carry that slot number in `out_qslot[SW*k +: SW]`.
- R6: When a triangle continues past a full chunk, its uniform is written again into slot 0 of the new chunk.
- R7: An accepted quad with `in_last` = 1 commits the chunk if it then holds at least one quad. In a committed chunk, the live bits, positions, slot numbers and uniform words of unused slots are 0. An empty chunk is never committed.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and all chunk outputs hold their values.
- R9: `out_nquads` gives the number of quads in the chunk and `out_nuni` the number of uniform slots used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Quad present |
| in_ready | output | 1 | Quad accepted this cycle when valid |
| in_mask | input | 4 | Coverage of the quad's four fragments |
| in_x | input | XW | Quad x position |
| in_y | input | YW | Quad y position |
| in_first | input | 1 | First quad of a triangle |
| in_last | input | 1 | Last quad of the stream; flush |
| in_uni | input | UW | Uniform word of the quad's triangle |
| out_valid | output | 1 | Committed chunk present |
| out_ready | input | 1 | Consumer takes the chunk |
| out_live | output | 4*QPC | Per-fragment liveness |
| out_qx | output | QPC*XW | Per-quad x positions |
| out_qy | output | QPC*YW | Per-quad y positions |
| out_qslot | output | QPC*SW | Per-quad uniform slot index |
| out_uni | output | QPC*UW | Uniform table |
| out_nquads | output | CW | Quads used |
| out_nuni | output | CW | Uniform slots used |

## Verification
The bench targets the following corner cases:
- **Empty quads.** It runs all sixteen coverage masks through one long triangle. A design that appended empty quads would emit chunks with dead slots and the wrong count.
- **Triangles that span chunks.** A design that forgot to clear its per-triangle flag at a commit would reference a uniform slot that does not exist in the new chunk.
- **Flush edge cases.** The stream ends exactly on a full chunk, and also ends on an empty quad after a full chunk. A wrong flush would send an empty or duplicated chunk.
- **Backpressure.** Periodic stalls on the output show whether a design loses or overwrites a chunk while the consumer is not ready.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int FPQ = 4; // fragments per quad

  // low bit index of a quad's fragments inside the liveness vector
  function automatic int unsigned frag_lo(input int unsigned slot);
    return slot * FPQ;
  endfunction

  // mask with one bit set for every fragment of the first nq quads
  function automatic logic [63:0] used_frags(input int unsigned nq);
    return (64'd1 << (nq * FPQ)) - 64'd1;
  endfunction
endpackage

// File: rtl/fcp_quad_gate.sv
module fcp_quad_gate (
  input  logic       in_valid,
  input  logic       in_ready,
  input  logic [3:0] in_mask,
  output logic       take,
  output logic       app
);
  assign take = in_valid && in_ready;
  assign app  = take && (in_mask != 4'd0);
endmodule

// File: rtl/fcp_chunk_accum.sv
module fcp_chunk_accum #(
  parameter int QPC = 4,
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int UW  = 8,
  localparam int SW = $clog2(QPC),
  localparam int CW = $clog2(QPC + 1),
  localparam int LW = fcp_pkg::FPQ * QPC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              app,
  input  logic [3:0]        mask,
  input  logic [XW-1:0]     x,
  input  logic [YW-1:0]     y,
  input  logic              first,
  input  logic              last,
  input  logic [UW-1:0]     uni,
  output logic              commit,
  output logic [LW-1:0]     n_live,
  output logic [QPC*XW-1:0] n_qx,
  output logic [QPC*YW-1:0] n_qy,
  output logic [QPC*SW-1:0] n_qs,
  output logic [QPC*UW-1:0] n_uv,
  output logic [CW-1:0]     n_cnt,
  output logic [CW-1:0]     n_nu
);
  import fcp_pkg::*;

  logic [LW-1:0]     live;
  logic [QPC*XW-1:0] qx;
  logic [QPC*YW-1:0] qy;
  logic [QPC*SW-1:0] qs;
  logic [QPC*UW-1:0] uv;
  logic [CW-1:0]     cnt, nu;
  logic [SW-1:0]     cur_slot, slot_sel;
  logic              tri_has, new_slot, full;

  assign new_slot = app && (first || !tri_has);
  assign slot_sel = new_slot ? nu[SW-1:0] : cur_slot;
  assign n_cnt    = cnt + CW'(app);
  assign n_nu     = nu + CW'(new_slot);
  assign full     = app && (cnt == CW'(QPC - 1));
  assign commit   = full || (take && last && (n_cnt != '0));

  always_comb begin
    n_live = live;
    n_qx   = qx;
    n_qy   = qy;
    n_qs   = qs;
    n_uv   = uv;
    for (int k = 0; k < QPC; k++) begin
      if (app && cnt == CW'(k)) begin
        n_live[frag_lo(k) +: FPQ] = mask;
        n_qx[k*XW +: XW] = x;
        n_qy[k*YW +: YW] = y;
        n_qs[k*SW +: SW] = slot_sel;
      end
      if (new_slot && nu == CW'(k)) n_uv[k*UW +: UW] = uni;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || commit) begin
      live <= '0; qx <= '0; qy <= '0; qs <= '0; uv <= '0;
      cnt <= '0; nu <= '0; cur_slot <= '0; tri_has <= 1'b0;
    end else if (take) begin
      live <= n_live; qx <= n_qx; qy <= n_qy; qs <= n_qs; uv <= n_uv;
      cnt <= n_cnt; nu <= n_nu;
      if (app) begin
        cur_slot <= slot_sel;
        tri_has  <= 1'b1;
      end else if (first) begin
        tri_has  <= 1'b0;
      end
    end
  end

  // R2: an empty quad that does not flush leaves the fill state alone
  a_r2_empty_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !app && !commit) |=> (cnt == $past(cnt) && nu == $past(nu) && live == $past(live)));
  // R4: the open chunk never reaches QPC quads
  a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(QPC));
  // R5: uniform slots never exceed quads held
  a_r5_slots: assert property (@(posedge clk) disable iff (!rst_n)
    nu <= cnt);
endmodule

// File: rtl/fcp_out_hold.sv
module fcp_out_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R8: a chunk waiting on the consumer does not move
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(q)));
endmodule

// File: rtl/frag_chunk_packer.sv
module frag_chunk_packer #(
  parameter int QPC = 4,
  parameter int XW  = 8,
  parameter int YW  = 8,
  parameter int UW  = 8,
  localparam int SW = $clog2(QPC),
  localparam int CW = $clog2(QPC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_mask,
  input  logic [XW-1:0]     in_x,
  input  logic [YW-1:0]     in_y,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [UW-1:0]     in_uni,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [4*QPC-1:0]  out_live,
  output logic [QPC*XW-1:0] out_qx,
  output logic [QPC*YW-1:0] out_qy,
  output logic [QPC*SW-1:0] out_qslot,
  output logic [QPC*UW-1:0] out_uni,
  output logic [CW-1:0]     out_nquads,
  output logic [CW-1:0]     out_nuni
);
  import fcp_pkg::*;
  localparam int LW = FPQ * QPC;
  localparam int BW = LW + QPC * (XW + YW + SW + UW) + 2 * CW;

  logic              take, app, commit;
  logic [LW-1:0]     n_live;
  logic [QPC*XW-1:0] n_qx;
  logic [QPC*YW-1:0] n_qy;
  logic [QPC*SW-1:0] n_qs;
  logic [QPC*UW-1:0] n_uv;
  logic [CW-1:0]     n_cnt, n_nu;
  logic [BW-1:0]     bundle_d, bundle_q;

  assign in_ready = !out_valid || out_ready;

  fcp_quad_gate u_gate (
    .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask),
    .take(take), .app(app)
  );

  fcp_chunk_accum #(.QPC(QPC), .XW(XW), .YW(YW), .UW(UW)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .app(app), .mask(in_mask),
    .x(in_x), .y(in_y), .first(in_first), .last(in_last), .uni(in_uni),
    .commit(commit), .n_live(n_live), .n_qx(n_qx), .n_qy(n_qy),
    .n_qs(n_qs), .n_uv(n_uv), .n_cnt(n_cnt), .n_nu(n_nu)
  );

  assign bundle_d = {n_live, n_qx, n_qy, n_qs, n_uv, n_cnt, n_nu};

  fcp_out_hold #(.W(BW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(commit), .d(bundle_d),
    .ready(out_ready), .valid(out_valid), .q(bundle_q)
  );

  assign {out_live, out_qx, out_qy, out_qslot, out_uni, out_nquads, out_nuni} = bundle_q;

  // R8: input is closed while a committed chunk is refused
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R7: a committed chunk is never empty
  a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nquads != '0));
  // R7: fragments of unused quad slots are dead
  a_r7_tail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((64'(out_live) & ~used_frags(out_nquads)) == 64'd0));
  // R9: at least one and at most nquads uniform slots per chunk
  a_r9_counts: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nuni != '0 && out_nuni <= out_nquads));
endmodule

// File: tb/sim_frag_chunk_packer.sv
`timescale 1ns/1ps
module sim_frag_chunk_packer;
  localparam int QPC = 4, XW = 8, YW = 8, UW = 8, SW = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [3:0] in_mask = '0;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic [UW-1:0] in_uni = '0;
  logic in_ready, out_valid;
  logic [15:0] out_live;
  logic [31:0] out_qx, out_qy, out_uni;
  logic [7:0]  out_qslot;
  logic [CW-1:0] out_nquads, out_nuni;

  always #4 clk = ~clk;

  frag_chunk_packer #(.QPC(QPC), .XW(XW), .YW(YW), .UW(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_x(in_x), .in_y(in_y), .in_first(in_first),
    .in_last(in_last), .in_uni(in_uni), .out_valid(out_valid),
    .out_ready(out_ready), .out_live(out_live), .out_qx(out_qx),
    .out_qy(out_qy), .out_qslot(out_qslot), .out_uni(out_uni),
    .out_nquads(out_nquads), .out_nuni(out_nuni)
  );

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected chunk queues
  logic [15:0] e_live[$];
  logic [31:0] e_qx[$], e_qy[$], e_uv[$];
  logic [7:0]  e_qs[$];
  int          e_nq[$], e_nu[$];

  // bench model of the open chunk
  logic [15:0] b_live = '0;
  logic [31:0] b_qx = '0, b_qy = '0, b_uv = '0;
  logic [7:0]  b_qs = '0;
  int mn = 0, mnu = 0, cur = 0;
  bit mtri = 0;

  task automatic push_chunk();
    e_live.push_back(b_live); e_qx.push_back(b_qx); e_qy.push_back(b_qy);
    e_uv.push_back(b_uv); e_qs.push_back(b_qs);
    e_nq.push_back(mn); e_nu.push_back(mnu);
    b_live = '0; b_qx = '0; b_qy = '0; b_uv = '0; b_qs = '0;
    mn = 0; mnu = 0; mtri = 0;
  endtask

  task automatic model(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                       input bit f, input bit l, input logic [7:0] u);
    if (f) mtri = 0;
    if (m != 4'd0) begin
      if (!mtri) begin          // R5 / R6 slot allocation
        b_uv[mnu*8 +: 8] = u;
        cur = mnu; mnu++; mtri = 1;
      end
      b_live[mn*4 +: 4] = m;    // R3 placement
      b_qx[mn*8 +: 8] = x;
      b_qy[mn*8 +: 8] = y;
      b_qs[mn*2 +: 2] = cur[1:0];
      mn++;
      if (mn == QPC) push_chunk();   // R4
    end
    if (l && mn != 0) push_chunk();  // R7
  endtask

  task automatic send(input logic [3:0] m, input logic [7:0] x, input logic [7:0] y,
                      input bit f, input bit l, input logic [7:0] u);
    @(negedge clk);
    in_mask = m; in_x = x; in_y = y; in_first = f; in_last = l; in_uni = u;
    in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    model(m, x, y, f, l, u);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  int rmode = 0, cyc = 0;
  bit started = 0;

  // consumer side
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) == 0);
      #1;
      if (started && out_valid && !out_ready)
        chk(!in_ready, "R8 in_ready low during stall", 64'(in_ready), 64'd0);
      if (started && out_valid && out_ready) begin
        if (e_live.size() == 0) begin
          chk(0, "R7 unexpected chunk", 64'(out_nquads), 64'd0);
        end else begin
          logic [15:0] xl; logic [31:0] xx, xy, xu; logic [7:0] xs; int xq, xn;
          xl = e_live.pop_front(); xx = e_qx.pop_front(); xy = e_qy.pop_front();
          xu = e_uv.pop_front(); xs = e_qs.pop_front();
          xq = e_nq.pop_front(); xn = e_nu.pop_front();
          chk(out_live == xl, "R2 R3 R4 R7 live mask", 64'(out_live), 64'(xl));
          chk(out_qx == xx && out_qy == xy, "R3 positions", {out_qx, out_qy}, {xx, xy});
          chk(out_qslot == xs, "R5 R6 slot index", 64'(out_qslot), 64'(xs));
          chk(out_uni == xu, "R5 R6 uniform table", 64'(out_uni), 64'(xu));
          chk(out_nquads == CW'(xq) && out_nuni == CW'(xn), "R9 counts",
              {out_nquads, out_nuni}, {CW'(xq), CW'(xn)});
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    started = 1;

    // all sixteen masks in one triangle: empties skipped (R2), fills (R4), re-uniform (R6)
    for (int i = 0; i < 16; i++)
      send(4'(i), 8'(i), 8'(i * 3), i == 0, i == 15, 8'hA5);

    // one-quad triangles under output stalls (R5, R8)
    rmode = 1;
    for (int t = 0; t < 11; t++)
      send(4'((t * 5) % 16), 8'(t + 40), 8'(t * 7), 1'b1, t == 10, 8'(t * 17 + 1));

    // triangles of length 1..6 with mixed coverage
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i <= t % 6; i++)
        send(4'(((t + i) * 7) % 16), 8'(t * 16 + i), 8'(i * 9 + t), i == 0,
             (t == 11) && (i == t % 6), 8'(t + 100));
    end

    // stream ends exactly at a full chunk (R4 R7)
    rmode = 0;
    for (int i = 0; i < 8; i++)
      send(4'hF, 8'(200 + i), 8'(i), i == 0, i == 7, 8'h3C);

    // full chunk then a final empty quad: no extra chunk (R7)
    for (int i = 0; i < 4; i++)
      send(4'(i + 1), 8'(i), 8'(250 - i), 1'b1, 1'b0, 8'(i + 60));
    send(4'h0, 8'd9, 8'd9, 1'b0, 1'b1, 8'h63);

    // empty triangles between covered ones, then partial flush (R2 R7)
    rmode = 1;
    send(4'h0, 8'd1, 8'd1, 1'b1, 1'b0, 8'h11);
    send(4'h8, 8'd2, 8'd2, 1'b1, 1'b0, 8'h22);
    send(4'h0, 8'd3, 8'd3, 1'b1, 1'b0, 8'h33);
    send(4'h1, 8'd4, 8'd4, 1'b0, 1'b1, 8'h33);

    repeat (20) @(posedge clk);
    #1;
    chk(e_live.size() == 0, "R7 all expected chunks delivered", 64'(e_live.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule